// File: doc/BRIEF.md
# Routed I/O Interrupt Controller

This block gathers thirty-two interrupt lines from peripherals and delivers them to a grid of processor interrupt inputs: four cores with four interrupt pins each. Each source is configured on its own. It can be level-sensitive or edge-sensitive, and it can be active high (rising) or active low (falling). A per-source routing byte chooses which core and which pin the source reaches. Sources arrive asynchronously. Each one passes through a two-flop synchronizer and one further delay flop, and the delay flop provides the edge detection.

Software configures and services the block through a simple word-wide register bus with byte strobes. Reads are combinational. Enabling and disabling use separate set and clear registers, so that no read-modify-write is needed. To service an interrupt, software reads the raw status and the enable mask and ANDs them. If that result is empty, the interrupt is treated as spurious. An edge latch is acknowledged by writing a one to its raw-status bit.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every source is disabled, level-triggered and active-high, every routing byte reads 0x11, and all sixteen outputs are low.
- R2: A full-word write to the enable-set register (byte offset 0x28) enables each source whose data bit is 1. A write to the enable-clear register (0x2C) disables each such source. Zero bits change nothing. The enable mask reads back at 0x24, and writes to 0x24 are ignored.
- R3: In level mode (edge bit 0), raw status bit i equals the input when polarity bit i is 1 and its inverse when it is 0. An input change made just after a clock edge reaches the output after the second following rising edge.
- R4: In edge mode (edge bit 1), a rising edge (polarity 1) or a falling edge (polarity 0) sets a latched status bit. The latch becomes visible after the third rising edge following the input change. The bit stays set after the input returns, and the opposite edge sets nothing.
- R5: Writing 1 to a raw-status bit (offset 0x20) clears that source's edge latch. Writing 0 leaves it set. A new edge in the same cycle as the clear wins.
- R6: Output index c*4+p is high exactly when some enabled source with raw status 1 has bit c (core select, bits 3:0) and bit 4+p (pin select, bits 7:4) set in its routing byte.
- R7: A routing byte with an empty core nibble or an empty pin nibble delivers nowhere. A byte with several bits set delivers to every selected core/pin pair.
- R8: The routing byte of source i sits at byte offset i (word i/4, lane i%4). Only the byte lanes whose strobe bit is set are written.
- R9: A disabled source never drives an output, while its raw status still reads back at 0x20.
- R10: Polarity (0x30) and edge select (0x38) read back as written. The offsets 0x34 and the set/clear registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 32 | Asynchronous interrupt source lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address (bits 1:0 ignored) |
| reg_wdata | input | 32 | Write data |
| reg_wstrb | input | 4 | Byte-lane strobes, used by routing words |
| reg_rdata | output | 32 | Combinational read data |
| irq_out | output | 16 | Interrupt outputs, index core*4+pin |

## Verification
The bench builds the block with its default parameters: thirty-two sources, four cores, four pins and a two-stage synchronizer. These values put all sixteen outputs and the full routing region within reach. They also make the last routing byte (source 31 at offset 0x1F) and the lane-3 strobe reachable, which covers the top end of the address map. Because the synchronizer depth stays at its default, the bench can confirm the exact latency of both the level path and the edge path.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef struct packed {
    logic [3:0] pin;
    logic [3:0] core;
  } route_t;

  localparam logic [7:0] ROUTE_RESET = 8'h11;

  // level request seen through polarity
  function automatic logic level_active(logic s, logic pol);
    return ~(s ^ pol);
  endfunction

  // edge of the selected direction between two samples
  function automatic logic edge_seen(logic now_s, logic prev_s, logic pol);
    return pol ? (now_s & ~prev_s) : (~now_s & prev_s);
  endfunction

  // does a route byte reach core c / pin p
  function automatic logic route_hit(route_t r, int c, int p);
    return r.core[c] & r.pin[p];
  endfunction

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int NUM_SRC = 32,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] async_in,
  output logic [NUM_SRC-1:0] sync_q,
  output logic [NUM_SRC-1:0] prev_q
);
  logic [NUM_SRC-1:0] stg [STAGES+1];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= async_in;
  end

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  assign sync_q = stg[STAGES-1];
  assign prev_q = stg[STAGES];
endmodule

// File: rtl/irq_trigger_unit.sv
module irq_trigger_unit
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] sync_q,
  input  logic [NUM_SRC-1:0] prev_q,
  input  logic [NUM_SRC-1:0] edge_mask,
  input  logic [NUM_SRC-1:0] pol_mask,
  input  logic [NUM_SRC-1:0] rawclr_mask,
  output logic [NUM_SRC-1:0] edge_evt,
  output logic [NUM_SRC-1:0] latch_q,
  output logic [NUM_SRC-1:0] raw_status
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign edge_evt[i] = edge_mask[i] & edge_seen(sync_q[i], prev_q[i], pol_mask[i]);

    always_ff @(posedge clk) begin
      if (!rst_n)            latch_q[i] <= 1'b0;
      else if (!edge_mask[i]) latch_q[i] <= 1'b0;
      else                   latch_q[i] <= edge_evt[i] | (latch_q[i] & ~rawclr_mask[i]);
    end

    assign raw_status[i] = edge_mask[i] ? latch_q[i]
                                        : level_active(sync_q[i], pol_mask[i]);
  end
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic [DATA_W/8-1:0]  reg_wstrb,
  input  logic [NUM_SRC-1:0]   raw_status,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [NUM_SRC-1:0]   en_mask,
  output logic [NUM_SRC-1:0]   pol_mask,
  output logic [NUM_SRC-1:0]   edge_mask,
  output logic [NUM_SRC-1:0]   enset_mask,
  output logic [NUM_SRC-1:0]   enclr_mask,
  output logic [NUM_SRC-1:0]   rawclr_mask,
  output logic [NUM_SRC*8-1:0] route_flat
);
  localparam int LANES       = DATA_W / 8;
  localparam int WA_W        = ADDR_W - 2;
  localparam int ROUTE_WORDS = NUM_SRC / LANES;
  localparam int CTRL_W      = NUM_SRC / LANES;
  localparam logic [WA_W-1:0] W_RAW  = WA_W'(CTRL_W + 0);
  localparam logic [WA_W-1:0] W_ENST = WA_W'(CTRL_W + 1);
  localparam logic [WA_W-1:0] W_SET  = WA_W'(CTRL_W + 2);
  localparam logic [WA_W-1:0] W_CLR  = WA_W'(CTRL_W + 3);
  localparam logic [WA_W-1:0] W_POL  = WA_W'(CTRL_W + 4);
  localparam logic [WA_W-1:0] W_EDGE = WA_W'(CTRL_W + 6);

  logic [WA_W-1:0] word;
  logic            unused_lo;
  assign word      = reg_addr[ADDR_W-1:2];
  assign unused_lo = ^reg_addr[1:0];

  logic wr_pol, wr_edge;
  assign enset_mask  = (reg_we && word == W_SET) ? reg_wdata[NUM_SRC-1:0] : '0;
  assign enclr_mask  = (reg_we && word == W_CLR) ? reg_wdata[NUM_SRC-1:0] : '0;
  assign rawclr_mask = (reg_we && word == W_RAW) ? reg_wdata[NUM_SRC-1:0] : '0;
  assign wr_pol      = reg_we && word == W_POL;
  assign wr_edge     = reg_we && word == W_EDGE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_mask   <= '0;
      pol_mask  <= '1;
      edge_mask <= '0;
    end else begin
      en_mask <= (en_mask | enset_mask) & ~enclr_mask;
      if (wr_pol)  pol_mask  <= reg_wdata[NUM_SRC-1:0];
      if (wr_edge) edge_mask <= reg_wdata[NUM_SRC-1:0];
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_route
    localparam int RW = i / LANES;
    localparam int RL = i % LANES;
    logic wr_this;
    assign wr_this = reg_we && (word == WA_W'(RW)) && reg_wstrb[RL];
    always_ff @(posedge clk) begin
      if (!rst_n)       route_flat[i*8 +: 8] <= ROUTE_RESET;
      else if (wr_this) route_flat[i*8 +: 8] <= reg_wdata[RL*8 +: 8];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (int'(word) < ROUTE_WORDS)
      reg_rdata = route_flat[int'(word)*DATA_W +: DATA_W];
    else if (word == W_RAW)  reg_rdata[NUM_SRC-1:0] = raw_status;
    else if (word == W_ENST) reg_rdata[NUM_SRC-1:0] = en_mask;
    else if (word == W_POL)  reg_rdata[NUM_SRC-1:0] = pol_mask;
    else if (word == W_EDGE) reg_rdata[NUM_SRC-1:0] = edge_mask;
  end
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CORE = 4,
  parameter int NUM_PIN  = 4
) (
  input  logic [NUM_SRC-1:0]          pend,
  input  logic [NUM_SRC*8-1:0]        route_flat,
  output logic [NUM_CORE*NUM_PIN-1:0] irq_out
);
  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      always_comb begin
        irq_out[c*NUM_PIN+p] = 1'b0;
        for (int i = 0; i < NUM_SRC; i++)
          irq_out[c*NUM_PIN+p] |= pend[i] & route_hit(route_t'(route_flat[i*8 +: 8]), c, p);
      end
    end
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CORE = 4,
  parameter int NUM_PIN  = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int STAGES   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           irq_src,
  input  logic                         reg_we,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [DATA_W-1:0]            reg_wdata,
  input  logic [DATA_W/8-1:0]          reg_wstrb,
  output logic [DATA_W-1:0]            reg_rdata,
  output logic [NUM_CORE*NUM_PIN-1:0]  irq_out
);
  logic [NUM_SRC-1:0]   sync_q, prev_q, edge_evt, latch_q, raw_status;
  logic [NUM_SRC-1:0]   en_mask, pol_mask, edge_mask;
  logic [NUM_SRC-1:0]   enset_mask, enclr_mask, rawclr_mask, pend;
  logic [NUM_SRC*8-1:0] route_flat;

  irq_src_sync #(.NUM_SRC(NUM_SRC), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(irq_src), .sync_q(sync_q), .prev_q(prev_q)
  );

  irq_trigger_unit #(.NUM_SRC(NUM_SRC)) u_trig (
    .clk(clk), .rst_n(rst_n), .sync_q(sync_q), .prev_q(prev_q),
    .edge_mask(edge_mask), .pol_mask(pol_mask), .rawclr_mask(rawclr_mask),
    .edge_evt(edge_evt), .latch_q(latch_q), .raw_status(raw_status)
  );

  irq_reg_file #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wstrb(reg_wstrb), .raw_status(raw_status),
    .reg_rdata(reg_rdata), .en_mask(en_mask), .pol_mask(pol_mask),
    .edge_mask(edge_mask), .enset_mask(enset_mask), .enclr_mask(enclr_mask),
    .rawclr_mask(rawclr_mask), .route_flat(route_flat)
  );

  assign pend = raw_status & en_mask;

  irq_route_matrix #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_matrix (
    .pend(pend), .route_flat(route_flat), .irq_out(irq_out)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_SRC = 32,
  parameter int NUM_OUT = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] en_mask,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] latch_q,
  input logic [NUM_SRC-1:0] edge_mask,
  input logic [NUM_SRC-1:0] enset_mask,
  input logic [NUM_SRC-1:0] enclr_mask,
  input logic [NUM_SRC-1:0] rawclr_mask,
  input logic [NUM_OUT-1:0] irq_out
);
  AST_OUT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != '0) |-> (pend != '0)); // R6

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask == '0) |-> (irq_out == '0)); // R9

  AST_SET_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (enset_mask != '0) |=> ((en_mask & $past(enset_mask)) == $past(enset_mask))); // R2

  AST_CLR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (enclr_mask != '0) |=> ((en_mask & $past(enclr_mask)) == '0)); // R2

  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(latch_q) & ~$past(rawclr_mask) & edge_mask & $past(edge_mask) & ~latch_q) == '0)); // R4
endmodule

bind irq_route_ctrl irq_route_chk #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_CORE*NUM_PIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_mask(en_mask), .pend(pend), .latch_q(latch_q),
  .edge_mask(edge_mask), .enset_mask(enset_mask), .enclr_mask(enclr_mask),
  .rawclr_mask(rawclr_mask), .irq_out(irq_out)
);

// File: tb/tb_irq_route_ctrl.sv
`timescale 1ns/1ps
module tb_irq_route_ctrl;
  localparam logic [7:0] A_RAW = 8'h20, A_ENST = 8'h24, A_SET = 8'h28, A_CLR = 8'h2C,
                         A_POL = 8'h30, A_GAP = 8'h34, A_EDGE = 8'h38;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_wstrb = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_out;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_route_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wstrb(reg_wstrb), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] s = 4'hF);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_wstrb = s;
    @(negedge clk);
    reg_we = 1'b0; reg_wstrb = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // expected output vector for one active source with route byte r
  function automatic logic [15:0] exp_route(logic [7:0] r);
    logic [15:0] v = '0;
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 4; p++)
        if (r[c] && r[4+p]) v[c*4+p] = 1'b1;
    return v;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    for (int w = 0; w < 8; w++) begin
      rd(8'(w*4), d); chk("R1 route reset", d, 32'h1111_1111);
    end
    rd(A_ENST, d); chk("R1 enable reset", d, 32'h0);
    rd(A_POL, d);  chk("R1 polarity reset", d, 32'hFFFF_FFFF);
    rd(A_EDGE, d); chk("R1 edge reset", d, 32'h0);
    chk("R1 outputs low", {16'h0, irq_out}, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(A_SET, 32'h0000_00F0); rd(A_ENST, d); chk("R2 set", d, 32'h0000_00F0);
    wr(A_SET, 32'h0);         rd(A_ENST, d); chk("R2 set zero", d, 32'h0000_00F0);
    wr(A_CLR, 32'h0000_0030); rd(A_ENST, d); chk("R2 clear", d, 32'h0000_00C0);
    wr(A_CLR, 32'h0);         rd(A_ENST, d); chk("R2 clear zero", d, 32'h0000_00C0);
    wr(A_ENST, 32'hFFFF_FFFF); rd(A_ENST, d); chk("R2 status write ignored", d, 32'h0000_00C0);
    rd(A_SET, d); chk("R10 set reads zero", d, 32'h0);
    rd(A_CLR, d); chk("R10 clear reads zero", d, 32'h0);
    rd(A_GAP, d); chk("R10 gap reads zero", d, 32'h0);
    wr(A_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(A_SET, 32'h20);
    irq_src[5] = 1'b1;
    wait_n(1); chk("R3 latency early", {16'h0, irq_out}, 32'h0);
    wait_n(1); chk("R3 level high", {16'h0, irq_out}, 32'h1);
    rd(A_RAW, d); chk("R3 raw high", d, 32'h20);
    irq_src[5] = 1'b0;
    wait_n(2); chk("R3 level drop", {16'h0, irq_out}, 32'h0);
    wr(A_POL, 32'hFFFF_FFDF);
    chk("R3 active low idle", {16'h0, irq_out}, 32'h1);
    rd(A_POL, d); chk("R10 polarity readback", d, 32'hFFFF_FFDF);
    irq_src[5] = 1'b1;
    wait_n(2); chk("R3 active low driven", {16'h0, irq_out}, 32'h0);
    irq_src[5] = 1'b0;
    wr(A_POL, 32'hFFFF_FFFF);
    wait_n(2);
    wr(A_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(A_EDGE, 32'h80);
    rd(A_EDGE, d); chk("R10 edge readback", d, 32'h80);
    wr(A_SET, 32'h80);
    irq_src[7] = 1'b1;
    wait_n(2); chk("R4 edge not yet", {16'h0, irq_out}, 32'h0);
    wait_n(1); chk("R4 rising latched", {16'h0, irq_out}, 32'h1);
    irq_src[7] = 1'b0;
    wait_n(4); chk("R4 latch holds", {16'h0, irq_out}, 32'h1);
    rd(A_RAW, d); chk("R4 raw latched", d, 32'h80);
    wr(A_RAW, 32'h0);  chk("R5 zero keeps", {16'h0, irq_out}, 32'h1);
    wr(A_RAW, 32'h80); chk("R5 one clears", {16'h0, irq_out}, 32'h0);
    wr(A_POL, 32'hFFFF_FF7F);
    irq_src[7] = 1'b1;
    wait_n(4); chk("R4 rising ignored in falling mode", {16'h0, irq_out}, 32'h0);
    irq_src[7] = 1'b0;
    wait_n(2); chk("R4 falling not yet", {16'h0, irq_out}, 32'h0);
    wait_n(1); chk("R4 falling latched", {16'h0, irq_out}, 32'h1);
    wr(A_RAW, 32'h80); chk("R5 clear falling", {16'h0, irq_out}, 32'h0);
    wr(A_POL, 32'hFFFF_FFFF);
    wr(A_EDGE, 32'h0);
    wr(A_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic t_route();
    logic [31:0] d;
    logic [7:0]  r;
    wr(A_SET, 32'h200);
    irq_src[9] = 1'b1;
    wait_n(2);
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 4; p++) begin
        r = 8'((1 << (4+p)) | (1 << c));
        wr(8'h08, {16'h0, r, 8'h0}, 4'b0010);
        chk("R6 core/pin select", {16'h0, irq_out}, {16'h0, exp_route(r)});
      end
    rd(8'h08, d); chk("R8 lane write only", d, 32'h1111_8811);
    wr(8'h08, 32'h0000_0100, 4'b0010); chk("R7 empty pin nibble", {16'h0, irq_out}, 32'h0);
    wr(8'h08, 32'h0000_1000, 4'b0010); chk("R7 empty core nibble", {16'h0, irq_out}, 32'h0);
    wr(8'h08, 32'h0000_3300, 4'b0010); chk("R7 multicast", {16'h0, irq_out}, 32'h0033);
    irq_src[9] = 1'b0;
    wr(8'h08, 32'h0000_1100, 4'b0010);
    wait_n(2);
    wr(A_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    irq_src[12] = 1'b1;
    wait_n(3);
    rd(A_RAW, d); chk("R9 raw shows masked source", d, 32'h1000);
    chk("R9 masked source silent", {16'h0, irq_out}, 32'h0);
    wr(A_SET, 32'h1000); chk("R9 enable delivers", {16'h0, irq_out}, 32'h1);
    irq_src[12] = 1'b0;
    wait_n(2);
    wr(A_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic t_boundary();
    logic [31:0] d;
    wr(8'h1C, 32'h8800_0000, 4'b1000);
    rd(8'h1C, d); chk("R8 last byte offset", d, 32'h8811_1111);
    wr(A_SET, 32'h8000_0000);
    irq_src[31] = 1'b1;
    wait_n(2); chk("R6 source 31 to core3 pin3", {16'h0, irq_out}, 32'h8000);
    irq_src[31] = 1'b0;
    wait_n(2); chk("R3 source 31 released", {16'h0, irq_out}, 32'h0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_enable();
    t_level();
    t_edge();
    t_route();
    t_mask();
    t_boundary();
    done = 1;
    summary();
  end
endmodule